// File: doc/BRIEF.md
# Kick-Updated Multi-Domain Clock Divider

Eight integer clock dividers share one fast source clock. Each domain gets its divide ratio from a 4-bit code in one of two 32-bit control words. The codes map through a fixed table that includes odd and non-binary ratios. Software writes a control word through a simple write/read port. The written codes land in shadow registers and do not disturb the running dividers.

Writing the kick bit takes a snapshot of all shadow codes. Each divider then adopts its new code at the end of its current output period, so no pulse is cut short. The kick bit stays readable as 1, and the busy output stays high, until every domain has switched. Three domains run at divide-by-2 from reset. The other five hold their output low until the first kick.

Top module: `kick_div_bank`

## Requirements
- R1: After reset, every field reads code 0 (divide by 2), both control words read 0x00000000, and `busy_o` is 0.
- R2: From reset, domains 0, 1 and 2 divide by 2. Domains 3 to 7 hold `div_o` low until they take up a setting after the first kick.
- R3: Address 0 holds domain 4 at bits [3:0], domain 3 at [7:4], domain 2 at [11:8], domain 1 at [15:12] and domain 0 at [23:20]. Address 1 holds domain 7 at [7:4], domain 6 at [11:8], domain 5 at [15:12] and the kick bit at bit 31. All other bits read 0.
- R4: Codes 0 to 12 select ratios 2, 3, 4, 6, 8, 12, 16, 18, 24, (none), 36, 48 and 10.
- R5: Code 9 and codes 13 to 15 are illegal in every domain. Code 12 is legal only in domains 1, 3 and 4. A write of an illegal code leaves that field at its previous value. Other fields in the same word still update.
- R6: A write without the kick bit changes only the read-back value. It has no effect on any `div_o`.
- R7: Writing address 1 with bit 31 set starts a switch. Bit 31 then reads 1 and `busy_o` is high until every domain has switched, after which both clear without further writes.
- R8: A domain changes ratio only at the end of its current output period. Every high pulse is as long as one of the table's ratios allows.
- R9: With ratio N, `div_o` has a period of N source cycles and is high for floor(N/2) of them. Even ratios give a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control words |
| reg_addr_i | input | 1 | Word select: 0 for the first word, 1 for the second |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word (combinational) |
| div_o | output | 8 | Divided clock for each domain |
| busy_o | output | 1 | A kick is pending |

## Verification
- A corrupted divider counter or code shows up on `div_o` within one output period. The period or the high time then no longer matches the table, and the bench measures both directly.
- A wrong shadow value appears at once on the read port. It also appears on the outputs one period after the next kick.
- A lost completion flag leaves `busy_o` stuck high, and the bench's bounded wait catches this within about one 48-cycle period.
- A pulse shortened at a switch shows up as a high time that matches no table entry.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
  localparam int unsigned NDOM     = 8;
  localparam int unsigned NDOM_A   = 5;
  localparam int unsigned NRUN_RST = 3;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CNT_W    = 6;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned KICK_BIT = 31;
  localparam int unsigned NCODE    = 13;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic cnt_t ratio_of(code_t c);
    case (c)
      4'd0:    return 6'd2;
      4'd1:    return 6'd3;
      4'd2:    return 6'd4;
      4'd3:    return 6'd6;
      4'd4:    return 6'd8;
      4'd5:    return 6'd12;
      4'd6:    return 6'd16;
      4'd7:    return 6'd18;
      4'd8:    return 6'd24;
      4'd10:   return 6'd36;
      4'd11:   return 6'd48;
      4'd12:   return 6'd10;
      default: return 6'd2;
    endcase
  endfunction

  // domains 1, 3, 4 also accept the divide-by-10 code
  function automatic logic [NCODE-1:0] mask_of(int unsigned d);
    return (d == 1 || d == 3 || d == 4) ? 13'h1dff : 13'h0dff;
  endfunction

  function automatic logic legal(int unsigned d, code_t c);
    logic [NCODE-1:0] m;
    m = mask_of(d);
    return (c < code_t'(NCODE)) && m[c];
  endfunction

  function automatic int unsigned off_of(int unsigned d);
    case (d)
      0:       return 20;
      1:       return 12;
      2:       return 8;
      3:       return 4;
      4:       return 0;
      5:       return 12;
      6:       return 8;
      default: return 4;
    endcase
  endfunction

  function automatic logic in_b(int unsigned d);
    return d >= NDOM_A;
  endfunction
endpackage

// File: rtl/kdb_regs.sv
module kdb_regs
  import kdb_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   all_done_i,
  output code_t [NDOM-1:0]       shadow_o,
  output code_t [NDOM-1:0]       staged_o,
  output logic                   pending_o,
  output logic [DATA_W-1:0]      rdata_o
);
  code_t [NDOM-1:0] shadow_q, shadow_d, staged_q;
  logic             pending_q, kick_req;
  logic [DATA_W-1:0] img_a [NDOM+1];
  logic [DATA_W-1:0] img_b [NDOM+1];

  assign img_a[0] = '0;
  assign img_b[0] = '0;

  for (genvar g = 0; g < NDOM; g++) begin : g_fld
    localparam int unsigned OFF = off_of(g);
    localparam logic        SELB = in_b(g);
    logic [DATA_W-1:0] place;
    code_t             wf;
    assign wf          = wdata_i[OFF +: CODE_W];
    assign shadow_d[g] = (we_i && addr_i == SELB && legal(g, wf)) ? wf : shadow_q[g];
    assign place       = {{(DATA_W-CODE_W){1'b0}}, shadow_q[g]} << OFF;
    assign img_a[g+1]  = SELB ? img_a[g] : (img_a[g] | place);
    assign img_b[g+1]  = SELB ? (img_b[g] | place) : img_b[g];
  end

  assign kick_req = we_i && addr_i && wdata_i[KICK_BIT] && !pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      staged_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      if (kick_req) begin
        pending_q <= 1'b1;
        staged_q  <= shadow_d;
      end else if (pending_q && all_done_i) begin
        pending_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = addr_i ? img_b[NDOM] : img_a[NDOM];
    if (addr_i) rdata_o[KICK_BIT] = pending_q;
  end

  assign shadow_o  = shadow_q;
  assign staged_o  = staged_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/kdb_div.sv
module kdb_div
  import kdb_pkg::*;
#(
  parameter bit RUN_RST = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pending_i,
  input  code_t code_i,
  output logic  div_o,
  output logic  done_o,
  output code_t code_o,
  output logic  wrap_o
);
  code_t code_q;
  cnt_t  cnt_q, ratio, half;
  logic  run_q, done_q, last, bound, load;

  assign ratio = ratio_of(code_q);
  assign half  = ratio >> 1;
  assign last  = cnt_q == ratio - cnt_t'(1);
  assign bound = !run_q || last;   // idle domain is always at a boundary
  assign load  = pending_i && !done_q && bound;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      run_q  <= RUN_RST;
      done_q <= 1'b0;
    end else begin
      if (run_q) cnt_q <= last ? '0 : cnt_q + cnt_t'(1);
      if (load) begin
        code_q <= code_i;
        run_q  <= 1'b1;
        done_q <= 1'b1;
      end else if (!pending_i) begin
        done_q <= 1'b0;
      end
    end
  end

  assign div_o  = run_q && (cnt_q < half);
  assign done_o = done_q;
  assign code_o = code_q;
  assign wrap_o = bound;
endmodule

// File: rtl/kick_div_bank.sv
module kick_div_bank
  import kdb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [7:0]        div_o,
  output logic              busy_o
);
  code_t [NDOM-1:0]        shadow, staged;
  logic                    pending;
  logic [NDOM-1:0]         done_vec, wrap_vec;
  logic [NDOM*CODE_W-1:0]  code_flat, shadow_flat;

  kdb_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .all_done_i (&done_vec),
    .shadow_o   (shadow),
    .staged_o   (staged),
    .pending_o  (pending),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    code_t cur;
    kdb_div #(.RUN_RST(g < NRUN_RST)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pending_i (pending),
      .code_i    (staged[g]),
      .div_o     (div_o[g]),
      .done_o    (done_vec[g]),
      .code_o    (cur),
      .wrap_o    (wrap_vec[g])
    );
    assign code_flat[g*CODE_W +: CODE_W]   = cur;
    assign shadow_flat[g*CODE_W +: CODE_W] = shadow[g];
  end

  assign busy_o = pending;
endmodule

// File: rtl/kick_div_bank_chk.sv
module kick_div_bank_chk
  import kdb_pkg::*;
#(
  parameter int unsigned KICK_MAX = 64
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   busy_o,
  input logic                   reg_addr_i,
  input logic [31:0]            reg_rdata_o,
  input logic [7:0]             div_o,
  input logic [NDOM*CODE_W-1:0] shadow_flat,
  input logic [NDOM*CODE_W-1:0] code_flat,
  input logic [NDOM-1:0]        wrap_vec
);
  logic [NDOM*CODE_W-1:0] code_prev;
  logic [NDOM-1:0]        wrap_prev, chg, ok_vec;
  logic                   kicked;
  logic [7:0]             kick_cnt;

  for (genvar g = 0; g < NDOM; g++) begin : g_c
    assign chg[g]    = code_flat[g*CODE_W +: CODE_W] != code_prev[g*CODE_W +: CODE_W];
    assign ok_vec[g] = legal(g, shadow_flat[g*CODE_W +: CODE_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_prev <= '0;
      wrap_prev <= '0;
      kicked    <= 1'b0;
      kick_cnt  <= '0;
    end else begin
      code_prev <= code_flat;
      wrap_prev <= wrap_vec;
      kicked    <= kicked | busy_o;
      kick_cnt  <= busy_o ? ((kick_cnt == 8'hff) ? kick_cnt : kick_cnt + 8'd1) : 8'd0;
    end
  end

  AST_SHADOW_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &ok_vec);                                                  // R5
  AST_SWITCH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg & ~wrap_prev) == '0);                                 // R8
  AST_BUSY_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i |-> reg_rdata_o[KICK_BIT] == busy_o);           // R7
  AST_KICK_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_cnt <= 8'(KICK_MAX));                                 // R7
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kicked |-> div_o[NDOM-1:NRUN_RST] == '0);                 // R2
endmodule

bind kick_div_bank kick_div_bank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .div_o       (div_o),
  .shadow_flat (shadow_flat),
  .code_flat   (code_flat),
  .wrap_vec    (wrap_vec)
);

// File: tb/kick_div_bank_tb.sv
`timescale 1ns/1ps
module kick_div_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  div;
  logic        busy;
  int          checks = 0;
  int          errors = 0;
  int          hl [8];

  always #10 clk = ~clk;

  kick_div_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .div_o(div), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic measure(input int d, output int per, output int hi);
    int g = 0;
    int lo = 0;
    hi = 0;
    @(negedge clk);
    while (div[d] === 1'b1 && g < 200) begin @(negedge clk); g++; end
    while (div[d] !== 1'b1 && g < 400) begin @(negedge clk); g++; end
    while (div[d] === 1'b1 && g < 600) begin @(negedge clk); g++; hi++; end
    while (div[d] !== 1'b1 && g < 800) begin @(negedge clk); g++; lo++; end
    per = (g >= 800) ? 0 : hi + lo;
  endtask

  task automatic expect_div(input int d, input int n, input string req);
    int per, hi;
    measure(d, per, hi);
    chk(per == n, {req, " period"}, per, n);
    chk(hi == n / 2, {req, " high"}, hi, n / 2);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 200) begin @(negedge clk); g++; end
    chk(!busy, "R7 busy clears", busy, 0);
  endtask

  // R8: every high pulse has a legal length
  function automatic bit half_ok(int h);
    return h inside {1, 2, 3, 4, 5, 6, 8, 9, 12, 18, 24};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 8; d++) begin
        if (div[d]) hl[d]++;
        else if (hl[d] != 0) begin
          chk(half_ok(hl[d]), "R8 pulse length", hl[d], 0);
          hl[d] = 0;
        end
      end
    end
  end

  task automatic t_reset();
    logic [31:0] v;
    bit low = 1'b1;
    rd(1'b0, v); chk(v == 32'h0, "R1 word0", v, 0);
    rd(1'b1, v); chk(v == 32'h0, "R1 word1", v, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    expect_div(0, 2, "R2 dom0");
    expect_div(1, 2, "R2 dom1");
    expect_div(2, 2, "R2 dom2");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (div[7:3] != 0) low = 1'b0;
    end
    chk(low, "R2 idle domains low", low, 1);
  endtask

  task automatic t_shadow();
    logic [31:0] v, e;
    e = (32'd1 << 20) | (32'd12 << 12) | (32'd4 << 8) | (32'd6 << 4) | 32'd2;
    wr(1'b0, e);
    rd(1'b0, v); chk(v == e, "R3 word0 readback", v, e);
    expect_div(0, 2, "R6 dom0 unchanged");
    expect_div(1, 2, "R6 dom1 unchanged");
    chk(div[7:3] == 0 && !busy, "R6 idle domains", div[7:3], 0);
  endtask

  task automatic t_kick();
    logic [31:0] v, e;
    e = (32'd10 << 12) | (32'd7 << 8) | (32'd8 << 4);
    wr(1'b1, e | 32'h8000_0000);
    chk(busy == 1'b1, "R7 busy set", busy, 1);
    rd(1'b1, v); chk(v == (e | 32'h8000_0000), "R7 kick reads 1", v, e | 32'h8000_0000);
    wait_idle();
    rd(1'b1, v); chk(v == e, "R3 word1 after kick", v, e);
    expect_div(0, 3, "R4 R9 code1");
    expect_div(1, 10, "R4 R9 code12");
    expect_div(2, 8, "R4 R9 code4");
    expect_div(3, 16, "R4 R9 code6");
    expect_div(4, 4, "R4 R9 code2");
    expect_div(5, 36, "R4 R9 code10");
    expect_div(6, 18, "R4 R9 code7");
    expect_div(7, 24, "R4 R9 code8");
  endtask

  task automatic t_illegal();
    logic [31:0] v, e;
    wr(1'b0, (32'd12 << 20) | (32'd9 << 12) | (32'd15 << 8) | (32'd0 << 4) | 32'd11);
    e = (32'd1 << 20) | (32'd12 << 12) | (32'd4 << 8) | (32'd0 << 4) | 32'd11;
    rd(1'b0, v); chk(v == e, "R5 word0 illegal kept", v, e);
    wr(1'b1, (32'd12 << 12) | (32'd3 << 8) | (32'd9 << 4));
    e = (32'd10 << 12) | (32'd3 << 8) | (32'd8 << 4);
    rd(1'b1, v); chk(v == e, "R5 word1 illegal kept", v, e);
  endtask

  task automatic t_switch();
    logic [31:0] e;
    e = (32'd10 << 12) | (32'd3 << 8) | (32'd8 << 4);
    wr(1'b1, e | 32'h8000_0000);
    wait_idle();
    expect_div(2, 8, "R8 dom2");
    expect_div(3, 2, "R8 dom3");
    expect_div(4, 48, "R8 dom4 code11");
    expect_div(6, 6, "R9 dom6 code3");
  endtask

  initial begin
    for (int d = 0; d < 8; d++) hl[d] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow();
    t_kick();
    t_illegal();
    t_switch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule